// File: doc/BRIEF.md
# Privilege Mode and Trap-Return Tracker

This block keeps the hart's current privilege level (Machine, Supervisor or User) in a register that no CSR exposes. The level changes only through trap entry and the three trap-return strobes. Alongside it sit the interrupt-enable, previous-enable and previous-privilege fields of the status register. The previous-privilege fields are sized per level: two bits for Machine, one bit for Supervisor, and none for User.

Each cycle the pipeline may present a trap, a return, a CSR access and an environment call. The block updates its state on the next clock edge. In the same cycle it reports an illegal-instruction flag and an exception cause. The illegal flag is raised by a CSR access from a mode that is too low, or by a return that is not allowed. The cause is the illegal-instruction code or the mode-dependent environment-call code. Parameters select whether Supervisor and User modes exist.

Top module: `priv_tracker`

## Requirements
- R1: Levels are encoded User = 2'b00, Supervisor = 2'b01, Machine = 2'b11. After reset the mode is Machine, every enable and previous-enable bit is 0, the Machine previous-privilege field is User and the Supervisor previous-privilege bit is 0. The mode never holds 2'b10.
- R2: A trap whose resolved target is Machine does four things on the next edge. It saves the current mode into the Machine previous-privilege field, moves the Machine enable bit into the Machine previous-enable bit, clears the Machine enable bit, and switches the mode to Machine.
- R3: A trap whose resolved target is Supervisor does four things on the next edge. It stores bit 0 of the current mode in the Supervisor previous-privilege bit, moves the Supervisor enable bit into the Supervisor previous-enable bit, clears the Supervisor enable bit, and switches the mode to Supervisor.
- R4: A trap target below the current mode resolves to the current mode. A requested target of 2'b10, or of a level that is not built, resolves to Machine.
- R5: MRET from Machine mode does four things on the next edge. It sets the mode to the Machine previous-privilege field, copies the Machine previous-enable bit into the Machine enable bit, sets the Machine previous-enable bit to 1, and resets the Machine previous-privilege field to User (Machine when User mode is not built).
- R6: SRET from Supervisor or Machine mode does four things on the next edge. It sets the mode to Supervisor if the Supervisor previous-privilege bit is 1 and to User otherwise. It copies the Supervisor previous-enable bit into the Supervisor enable bit, sets the Supervisor previous-enable bit to 1, and clears the Supervisor previous-privilege bit.
- R7: URET (return level 2'b00) does three things on the next edge. It copies the User previous-enable bit into the User enable bit, sets the User previous-enable bit to 1, and sets the mode to User. A trap resolved to User moves the User enable bit into the User previous-enable bit and clears the User enable bit.
- R8: MRET below Machine mode, SRET in User mode, and a return with level 2'b10 raise the illegal flag in the same cycle. Such a return changes no state.
- R9: A CSR access raises the illegal flag in the same cycle when the current mode is numerically below address bits [9:8]. For example, address 0x300 is illegal from Supervisor and User, and address 0x100 is illegal from User.
- R10: An environment call drives the cause-valid output in the same cycle. The cause is 8 from User, 9 from Supervisor and 11 from Machine.
- R11: While the illegal flag is high, cause-valid is high and the cause is 2, even when an environment call arrives in the same cycle.
- R12: When a trap and a return arrive in the same cycle, only the trap takes effect, and the return raises no illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Trap-entry strobe |
| trap_lvl_i | input | 2 | Requested trap target level |
| ret_i | input | 1 | Trap-return strobe |
| ret_lvl_i | input | 2 | Level of the return (11 MRET, 01 SRET, 00 URET) |
| csr_req_i | input | 1 | CSR access strobe |
| csr_addr_i | input | CSR_ADDR_W | CSR address |
| ecall_i | input | 1 | Environment-call strobe |
| mode_o | output | 2 | Current privilege level (hardware only) |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| uie_o | output | 1 | User interrupt enable |
| upie_o | output | 1 | User previous enable |
| illegal_o | output | 1 | Illegal-instruction flag |
| cause_valid_o | output | 1 | Cause output is meaningful |
| cause_o | output | CAUSE_W | Exception cause code |

## Verification
Two pairs of functions can land in the same cycle, and each pair is provoked by raising both strobes on one clock. The first pair is a trap and a return. It is judged by reading the status fields one edge later, which must show only the trap's effect, and by checking that the illegal flag stayed low. The second pair is a privileged CSR access and an environment call. It is judged within that cycle: the cause must be 2 when the access is too privileged and the mode-specific call code when it is allowed.

// File: rtl/priv_pkg.sv
package priv_pkg;
   localparam logic [1:0] LVL_U   = 2'b00;
   localparam logic [1:0] LVL_S   = 2'b01;
   localparam logic [1:0] LVL_RSV = 2'b10;
   localparam logic [1:0] LVL_M   = 2'b11;

   localparam int unsigned CODE_ILLEGAL   = 2;
   localparam int unsigned CODE_CALL_BASE = 8;

   // bitmap of implemented levels, indexed by encoding
   function automatic logic [3:0] level_map(input bit has_s, input bit has_u);
      level_map = {1'b1, 1'b0, logic'(has_s), logic'(has_u)};
   endfunction
endpackage

// File: rtl/priv_target_sel.sv
module priv_target_sel
   import priv_pkg::*;
#(
   parameter bit HAS_SUPER = 1'b1,
   parameter bit HAS_USER  = 1'b1
) (
   input  logic [1:0] mode_i,
   input  logic [1:0] req_lvl_i,
   output logic [1:0] tgt_o
);
   localparam logic [3:0] BUILT = level_map(HAS_SUPER, HAS_USER);

   logic [1:0] fixed_lvl;

   always_comb begin
      fixed_lvl = BUILT[req_lvl_i] ? req_lvl_i : LVL_M;
      tgt_o     = (fixed_lvl < mode_i) ? mode_i : fixed_lvl;
   end

   always_comb begin
      a_r4_target_not_rsv: assert (tgt_o != LVL_RSV);
   end
endmodule

// File: rtl/priv_ret_check.sv
module priv_ret_check
   import priv_pkg::*;
#(
   parameter bit HAS_SUPER = 1'b1,
   parameter bit HAS_USER  = 1'b1
) (
   input  logic [1:0] mode_i,
   input  logic       trap_i,
   input  logic       ret_i,
   input  logic [1:0] ret_lvl_i,
   output logic       ret_fire_o,
   output logic       ret_bad_o
);
   localparam logic [3:0] BUILT = level_map(HAS_SUPER, HAS_USER);

   logic lvl_ok;

   always_comb begin
      lvl_ok     = BUILT[ret_lvl_i] && !(ret_lvl_i > mode_i);
      ret_fire_o = ret_i && !trap_i && lvl_ok;
      ret_bad_o  = ret_i && !trap_i && !lvl_ok;
   end

   always_comb begin
      a_r8_fire_bad_excl: assert (!(ret_fire_o && ret_bad_o));
   end
endmodule

// File: rtl/priv_csr_gate.sv
module priv_csr_gate #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned FIELD_LSB = 8
) (
   input  logic [1:0]        mode_i,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              deny_o
);
   localparam int unsigned FIELD_MSB = FIELD_LSB + 1;

   generate
      if (FIELD_MSB >= ADDR_W) begin : g_bad_field
         $error("privilege field lies outside the CSR address");
      end
   endgenerate

   logic [1:0] need_lvl;
   logic       unused_addr_bits;

   assign need_lvl         = addr_i[FIELD_MSB:FIELD_LSB];
   assign unused_addr_bits = ^addr_i;
   assign deny_o           = req_i && (mode_i < need_lvl);
endmodule

// File: rtl/priv_cause_enc.sv
module priv_cause_enc
   import priv_pkg::*;
#(
   parameter int unsigned CAUSE_W = 5
) (
   input  logic [1:0]         mode_i,
   input  logic               illegal_i,
   input  logic               ecall_i,
   output logic               valid_o,
   output logic [CAUSE_W-1:0] cause_o
);
   generate
      if (CAUSE_W < 4) begin : g_bad_width
         $error("cause width too narrow for call codes");
      end
   endgenerate

   localparam logic [CAUSE_W-1:0] ILL_CODE  = CAUSE_W'(CODE_ILLEGAL);
   localparam logic [CAUSE_W-1:0] CALL_BASE = CAUSE_W'(CODE_CALL_BASE);

   always_comb begin
      valid_o = illegal_i || ecall_i;
      if (illegal_i) cause_o = ILL_CODE;
      else if (ecall_i) cause_o = CALL_BASE + CAUSE_W'(mode_i);
      else cause_o = '0;
   end
endmodule

// File: rtl/priv_status_regs.sv
module priv_status_regs
   import priv_pkg::*;
#(
   parameter bit HAS_SUPER = 1'b1,
   parameter bit HAS_USER  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trap_fire_i,
   input  logic [1:0] trap_tgt_i,
   input  logic       ret_fire_i,
   input  logic [1:0] ret_lvl_i,
   output logic [1:0] mode_o,
   output logic       mie_o,
   output logic       mpie_o,
   output logic [1:0] mpp_o,
   output logic       sie_o,
   output logic       spie_o,
   output logic       spp_o,
   output logic       uie_o,
   output logic       upie_o
);
   localparam logic [1:0] MPP_IDLE = HAS_USER ? LVL_U : LVL_M;

   logic [1:0] mode_q;
   logic       mie_q, mpie_q;
   logic [1:0] mpp_q;
   logic       sie_q, spie_q, spp_q;
   logic       uie_q, upie_q;

   logic trap_m, trap_s, trap_u;
   logic ret_m, ret_s, ret_u;

   always_comb begin
      trap_m = trap_fire_i && (trap_tgt_i == LVL_M);
      trap_s = trap_fire_i && (trap_tgt_i == LVL_S);
      trap_u = trap_fire_i && (trap_tgt_i == LVL_U);
      ret_m  = ret_fire_i && (ret_lvl_i == LVL_M);
      ret_s  = ret_fire_i && (ret_lvl_i == LVL_S);
      ret_u  = ret_fire_i && (ret_lvl_i == LVL_U);
   end

   // hidden current level
   always_ff @(posedge clk) begin
      if (!rst_n)           mode_q <= LVL_M;
      else if (trap_fire_i) mode_q <= trap_tgt_i;
      else if (ret_m)       mode_q <= mpp_q;
      else if (ret_s)       mode_q <= spp_q ? LVL_S : LVL_U;
      else if (ret_u)       mode_q <= LVL_U;
   end

   // machine-level fields
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mie_q  <= 1'b0;
         mpie_q <= 1'b0;
         mpp_q  <= MPP_IDLE;
      end else if (trap_m) begin
         mpp_q  <= mode_q;
         mpie_q <= mie_q;
         mie_q  <= 1'b0;
      end else if (ret_m) begin
         mie_q  <= mpie_q;
         mpie_q <= 1'b1;
         mpp_q  <= MPP_IDLE;
      end
   end

   generate
      if (HAS_SUPER) begin : g_super
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sie_q  <= 1'b0;
               spie_q <= 1'b0;
               spp_q  <= 1'b0;
            end else if (trap_s) begin
               spp_q  <= mode_q[0];
               spie_q <= sie_q;
               sie_q  <= 1'b0;
            end else if (ret_s) begin
               sie_q  <= spie_q;
               spie_q <= 1'b1;
               spp_q  <= 1'b0;
            end
         end

         a_r3_trap_s: assert property (@(posedge clk) disable iff (!rst_n)
            trap_s |=> (mode_q == LVL_S) && !sie_q && (spie_q == $past(sie_q))
                       && (spp_q == $past(mode_q[0])));

         a_r6_sret: assert property (@(posedge clk) disable iff (!rst_n)
            ret_s |=> spie_q && !spp_q && (sie_q == $past(spie_q)));
      end else begin : g_no_super
         assign sie_q  = 1'b0;
         assign spie_q = 1'b0;
         assign spp_q  = 1'b0;
      end

      if (HAS_USER) begin : g_user
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               uie_q  <= 1'b0;
               upie_q <= 1'b0;
            end else if (trap_u) begin
               upie_q <= uie_q;
               uie_q  <= 1'b0;
            end else if (ret_u) begin
               uie_q  <= upie_q;
               upie_q <= 1'b1;
            end
         end

         a_r7_uret: assert property (@(posedge clk) disable iff (!rst_n)
            ret_u |=> upie_q && (uie_q == $past(upie_q)) && (mode_q == LVL_U));
      end else begin : g_no_user
         assign uie_q  = 1'b0;
         assign upie_q = 1'b0;
      end
   endgenerate

   assign mode_o = mode_q;
   assign mie_o  = mie_q;
   assign mpie_o = mpie_q;
   assign mpp_o  = mpp_q;
   assign sie_o  = sie_q;
   assign spie_o = spie_q;
   assign spp_o  = spp_q;
   assign uie_o  = uie_q;
   assign upie_o = upie_q;

   a_r1_no_rsv_mode: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != LVL_RSV);

   a_r2_trap_m: assert property (@(posedge clk) disable iff (!rst_n)
      trap_m |=> (mode_q == LVL_M) && !mie_q && (mpie_q == $past(mie_q))
                 && (mpp_q == $past(mode_q)));

   a_r5_mret: assert property (@(posedge clk) disable iff (!rst_n)
      ret_m |=> mpie_q && (mie_q == $past(mpie_q)) && (mode_q == $past(mpp_q))
                && (mpp_q == MPP_IDLE));
endmodule

// File: rtl/priv_tracker.sv
module priv_tracker
   import priv_pkg::*;
#(
   parameter bit          HAS_SUPER  = 1'b1,
   parameter bit          HAS_USER   = 1'b1,
   parameter int unsigned CSR_ADDR_W = 12,
   parameter int unsigned CAUSE_W    = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trap_i,
   input  logic [1:0]            trap_lvl_i,
   input  logic                  ret_i,
   input  logic [1:0]            ret_lvl_i,
   input  logic                  csr_req_i,
   input  logic [CSR_ADDR_W-1:0] csr_addr_i,
   input  logic                  ecall_i,
   output logic [1:0]            mode_o,
   output logic                  mie_o,
   output logic                  mpie_o,
   output logic [1:0]            mpp_o,
   output logic                  sie_o,
   output logic                  spie_o,
   output logic                  spp_o,
   output logic                  uie_o,
   output logic                  upie_o,
   output logic                  illegal_o,
   output logic                  cause_valid_o,
   output logic [CAUSE_W-1:0]    cause_o
);
   logic [1:0] tgt;
   logic       ret_fire, ret_bad, csr_deny;

   priv_target_sel #(.HAS_SUPER(HAS_SUPER), .HAS_USER(HAS_USER)) u_tgt (
      .mode_i(mode_o), .req_lvl_i(trap_lvl_i), .tgt_o(tgt)
   );

   priv_ret_check #(.HAS_SUPER(HAS_SUPER), .HAS_USER(HAS_USER)) u_ret (
      .mode_i(mode_o), .trap_i(trap_i), .ret_i(ret_i), .ret_lvl_i(ret_lvl_i),
      .ret_fire_o(ret_fire), .ret_bad_o(ret_bad)
   );

   priv_csr_gate #(.ADDR_W(CSR_ADDR_W), .FIELD_LSB(8)) u_gate (
      .mode_i(mode_o), .req_i(csr_req_i), .addr_i(csr_addr_i), .deny_o(csr_deny)
   );

   assign illegal_o = csr_deny || ret_bad;

   priv_cause_enc #(.CAUSE_W(CAUSE_W)) u_cause (
      .mode_i(mode_o), .illegal_i(illegal_o), .ecall_i(ecall_i),
      .valid_o(cause_valid_o), .cause_o(cause_o)
   );

   priv_status_regs #(.HAS_SUPER(HAS_SUPER), .HAS_USER(HAS_USER)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .trap_fire_i(trap_i), .trap_tgt_i(tgt),
      .ret_fire_i(ret_fire), .ret_lvl_i(ret_lvl_i),
      .mode_o(mode_o), .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
      .sie_o(sie_o), .spie_o(spie_o), .spp_o(spp_o),
      .uie_o(uie_o), .upie_o(upie_o)
   );

   a_r8_bad_mret_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !trap_i && (ret_lvl_i == LVL_M) && (mode_o != LVL_M))
      |=> $stable(mode_o) && $stable(mie_o) && $stable(mpie_o) && $stable(mpp_o));

   a_r9_mcsr_denied: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req_i && (csr_addr_i[9:8] == 2'b11) && (mode_o != LVL_M)) |-> illegal_o);

   a_r11_illegal_cause: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> cause_valid_o && (cause_o == CAUSE_W'(CODE_ILLEGAL)));

   a_r12_trap_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_i && !csr_req_i) |-> !illegal_o);
endmodule

// File: tb/tb_priv_tracker.sv
module tb_priv_tracker;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        trap;
      logic [1:0]  tlvl;
      logic        ret;
      logic [1:0]  rlvl;
      logic        csr;
      logic [11:0] addr;
      logic        ecall;
      logic        ill;
      logic        cv;
      logic [4:0]  cause;
      logic [1:0]  mode;
      logic        mie;
      logic        mpie;
      logic [1:0]  mpp;
      logic        sie;
      logic        spie;
      logic        spp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t TBL [NV] = '{
      '{1'b0,2'd0,1'b0,2'd0,1'b0,12'h000,1'b1, 1'b0,1'b1,5'd11, 2'd3,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0, 4'd10}, // R10 M call
      '{1'b0,2'd0,1'b0,2'd0,1'b1,12'h300,1'b0, 1'b0,1'b0,5'd0,  2'd3,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0, 4'd9},  // R9 M csr ok
      '{1'b0,2'd0,1'b1,2'd3,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0, 4'd5},  // R5 to U
      '{1'b0,2'd0,1'b0,2'd0,1'b1,12'h100,1'b0, 1'b1,1'b1,5'd2,  2'd0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0, 4'd9},  // R9 U denied
      '{1'b0,2'd0,1'b0,2'd0,1'b0,12'h000,1'b1, 1'b0,1'b1,5'd8,  2'd0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0, 4'd10}, // R10 U call
      '{1'b0,2'd0,1'b1,2'd1,1'b0,12'h000,1'b0, 1'b1,1'b1,5'd2,  2'd0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0, 4'd8},  // R8 SRET in U
      '{1'b1,2'd1,1'b0,2'd0,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0, 4'd3},  // R3 U->S
      '{1'b0,2'd0,1'b0,2'd0,1'b1,12'h300,1'b0, 1'b1,1'b1,5'd2,  2'd1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0, 4'd9},  // R9 S denied
      '{1'b0,2'd0,1'b0,2'd0,1'b1,12'h100,1'b1, 1'b0,1'b1,5'd9,  2'd1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0, 4'd10}, // R10 S call
      '{1'b1,2'd3,1'b0,2'd0,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd3,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0, 4'd2},  // R2 S->M
      '{1'b0,2'd0,1'b1,2'd3,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0, 4'd5},  // R5 to S
      '{1'b0,2'd0,1'b1,2'd3,1'b0,12'h000,1'b0, 1'b1,1'b1,5'd2,  2'd1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0, 4'd8},  // R8 MRET in S
      '{1'b1,2'd0,1'b0,2'd0,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b1, 4'd4},  // R4 U target raised
      '{1'b0,2'd0,1'b1,2'd1,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd1,1'b0,1'b1,2'd0,1'b0,1'b1,1'b0, 4'd6},  // R6 back to S
      '{1'b1,2'd2,1'b0,2'd0,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd3,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0, 4'd4},  // R4 rsv -> M
      '{1'b1,2'd3,1'b1,2'd3,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd3,1'b0,1'b0,2'd3,1'b0,1'b1,1'b0, 4'd12}, // R12 trap wins
      '{1'b0,2'd0,1'b0,2'd0,1'b1,12'h300,1'b1, 1'b0,1'b1,5'd11, 2'd3,1'b0,1'b0,2'd3,1'b0,1'b1,1'b0, 4'd9},  // R9 legal + call
      '{1'b0,2'd0,1'b1,2'd3,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd3,1'b0,1'b1,2'd0,1'b0,1'b1,1'b0, 4'd5},  // R5 M->M
      '{1'b0,2'd0,1'b1,2'd3,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd0,1'b1,1'b1,2'd0,1'b0,1'b1,1'b0, 4'd5},  // R5 mie set
      '{1'b0,2'd0,1'b0,2'd0,1'b1,12'h300,1'b1, 1'b1,1'b1,5'd2,  2'd0,1'b1,1'b1,2'd0,1'b0,1'b1,1'b0, 4'd11}, // R11 priority
      '{1'b1,2'd3,1'b0,2'd0,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd3,1'b0,1'b1,2'd0,1'b0,1'b1,1'b0, 4'd2},  // R2 U->M
      '{1'b0,2'd0,1'b1,2'd1,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd0,1'b0,1'b1,2'd0,1'b1,1'b1,1'b0, 4'd6},  // R6 M->U
      '{1'b1,2'd1,1'b0,2'd0,1'b0,12'h000,1'b0, 1'b0,1'b0,5'd0,  2'd1,1'b0,1'b1,2'd0,1'b0,1'b1,1'b0, 4'd3},  // R3 spie <- 1
      '{1'b0,2'd0,1'b1,2'd2,1'b0,12'h000,1'b0, 1'b1,1'b1,5'd2,  2'd1,1'b0,1'b1,2'd0,1'b0,1'b1,1'b0, 4'd8}   // R8 rsv return
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        trap_i, ret_i, csr_req_i, ecall_i;
   logic [1:0]  trap_lvl_i, ret_lvl_i;
   logic [11:0] csr_addr_i;
   logic [1:0]  mode_o, mpp_o;
   logic        mie_o, mpie_o, sie_o, spie_o, spp_o, uie_o, upie_o;
   logic        illegal_o, cause_valid_o;
   logic [4:0]  cause_o;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   priv_tracker dut (
      .clk(clk), .rst_n(rst_n),
      .trap_i(trap_i), .trap_lvl_i(trap_lvl_i),
      .ret_i(ret_i), .ret_lvl_i(ret_lvl_i),
      .csr_req_i(csr_req_i), .csr_addr_i(csr_addr_i), .ecall_i(ecall_i),
      .mode_o(mode_o), .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
      .sie_o(sie_o), .spie_o(spie_o), .spp_o(spp_o),
      .uie_o(uie_o), .upie_o(upie_o),
      .illegal_o(illegal_o), .cause_valid_o(cause_valid_o), .cause_o(cause_o)
   );

   function automatic string rname(input logic [3:0] r);
      case (r)
         4'd1: rname = "R1";   4'd2: rname = "R2";   4'd3: rname = "R3";
         4'd4: rname = "R4";   4'd5: rname = "R5";   4'd6: rname = "R6";
         4'd7: rname = "R7";   4'd8: rname = "R8";   4'd9: rname = "R9";
         4'd10: rname = "R10"; 4'd11: rname = "R11"; default: rname = "R12";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      trap_i = 1'b0; trap_lvl_i = 2'd0; ret_i = 1'b0; ret_lvl_i = 2'd0;
      csr_req_i = 1'b0; csr_addr_i = 12'h000; ecall_i = 1'b0;
   endtask

   task automatic check_state(input string req, input logic [1:0] m, input logic mie,
                              input logic mpie, input logic [1:0] mpp, input logic sie,
                              input logic spie, input logic spp);
      chk(req, "mode", 32'(mode_o), 32'(m));
      chk(req, "mie",  32'(mie_o),  32'(mie));
      chk(req, "mpie", 32'(mpie_o), 32'(mpie));
      chk(req, "mpp",  32'(mpp_o),  32'(mpp));
      chk(req, "sie",  32'(sie_o),  32'(sie));
      chk(req, "spie", 32'(spie_o), 32'(spie));
      chk(req, "spp",  32'(spp_o),  32'(spp));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle_inputs();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, mode Machine, every enable clear
      check_state("R1", 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
      chk("R1", "uie", 32'(uie_o), 32'd0);
      chk("R1", "upie", 32'(upie_o), 32'd0);
      chk("R1", "illegal idle", 32'(illegal_o), 32'd0);
   endtask

   // strobe for one cycle, check same-cycle outputs, then next-edge state
   task automatic apply(input vec_t v, input int idx);
      string rq;
      rq = $sformatf("%s vec%0d", rname(v.req), idx);
      @(negedge clk);
      trap_i = v.trap; trap_lvl_i = v.tlvl; ret_i = v.ret; ret_lvl_i = v.rlvl;
      csr_req_i = v.csr; csr_addr_i = v.addr; ecall_i = v.ecall;
      #(CLK_PERIOD / 4);
      chk(rq, "illegal", 32'(illegal_o), 32'(v.ill));
      chk(rq, "cause_valid", 32'(cause_valid_o), 32'(v.cv));
      if (v.cv) chk(rq, "cause", 32'(cause_o), 32'(v.cause));
      @(posedge clk);
      #(CLK_PERIOD / 4);
      idle_inputs();
      #(CLK_PERIOD / 8);
      check_state(rq, v.mode, v.mie, v.mpie, v.mpp, v.sie, v.spie, v.spp);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0;
      idle_inputs();
      do_reset();

      for (int i = 0; i < NV; i++) apply(TBL[i], i);

      // R7: URET sequence and trap to User from User
      do_reset();
      @(negedge clk); ret_i = 1'b1; ret_lvl_i = 2'd0;
      #(CLK_PERIOD / 4);
      chk("R7", "uret legal", 32'(illegal_o), 32'd0);
      @(negedge clk); idle_inputs();
      chk("R7", "mode after uret", 32'(mode_o), 32'd0);
      chk("R7", "uie first", 32'(uie_o), 32'd0);
      chk("R7", "upie first", 32'(upie_o), 32'd1);
      ret_i = 1'b1; ret_lvl_i = 2'd0;
      @(negedge clk); idle_inputs();
      chk("R7", "uie second", 32'(uie_o), 32'd1);
      chk("R7", "upie second", 32'(upie_o), 32'd1);
      trap_i = 1'b1; trap_lvl_i = 2'd0;
      @(negedge clk); idle_inputs();
      chk("R7", "mode trap U", 32'(mode_o), 32'd0);
      chk("R7", "uie trap", 32'(uie_o), 32'd0);
      chk("R7", "upie trap", 32'(upie_o), 32'd1);
      chk("R7", "m fields untouched", 32'({mie_o, mpie_o, mpp_o}), 32'({1'b0, 1'b0, 2'd0}));

      // R1: reset in the middle of activity restores the reset state
      do_reset();

      // R9: user-level CSR address legal from User mode
      @(negedge clk); ret_i = 1'b1; ret_lvl_i = 2'd3;
      @(negedge clk); idle_inputs(); csr_req_i = 1'b1; csr_addr_i = 12'h001;
      #(CLK_PERIOD / 4);
      chk("R9", "user csr from U", 32'(illegal_o), 32'd0);
      @(negedge clk); idle_inputs();

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule